// File: doc/BRIEF.md
# Flash Thermometer Encoder

This block sits behind the comparator bank of a flash analog-to-digital converter. Its input is a 256-bit thermometer word, one bit per comparator. Bits 0 to 254 carry the in-range comparators, where bit k-1 is comparator k and threshold k. Bit 255 carries the overrange comparator. The block captures that word on each clock and produces an 8-bit straight binary sample together with an overrange flag.

Encoding goes through Gray code on the way to binary. Each Gray bit is the parity of a fixed set of thermometer taps, so one comparator out of order disturbs only a few low-order bits. The Gray word is registered, decoded to binary, and held in an output register. Two enables must both be high for the eight data lines to drive. Otherwise the data lines are released to high impedance. The overrange line keeps driving whatever the enables are.

The block accepts a new word on every clock. Each result appears three clocks after the word is captured.

Top module: `flash_therm_encoder`

## Requirements
- R1: A clock edge with `rst` high clears all three register stages, whatever `therm_i` holds, so the sample reads 0 and `ovr_o` reads 0.
- R2: For a clean level L (bits 0..L-1 set, all others clear, 0 <= L <= 255), the sample equals L.
- R3: A word captured at a rising edge appears on the outputs just after the third rising edge. After only two edges the outputs still show the previous result.
- R4: When bit 255 of the captured word is set, `ovr_o` is 1 and the sample is 255, regardless of bits 0..254.
- R5: When bit 255 of the captured word is clear, `ovr_o` is 0.
- R6: For a level L in 2..255 with one bubble (bit L-2, comparator L-1, cleared), the sample is within 3 of L.
- R7: `sample_o` drives the held sample only while `oe_a` and `oe_b` are both 1. If either is 0, the lines are released so that another driver on the same net sets their value.
- R8: `ovr_o` drives the held overrange result whatever `oe_a` and `oe_b` are.
- R9: A different word may be presented on every clock. The results come out in order, one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| therm_i | input | 256 | Comparator results; bit k-1 is comparator k, bit 255 is overrange |
| oe_a | input | 1 | Data output enable A, active high |
| oe_b | input | 1 | Data output enable B, active high |
| sample_o | output | 8 | Binary sample, three-state |
| ovr_o | output | 1 | Overrange flag, always driven |

## Verification
A streaming sweep applies every clean level from 0 to 256 on consecutive clocks. This shows that each Gray tap set and the decode are correct at every code boundary, and that results keep their order and their three-clock spacing. Bubble patterns clear the comparator just below the top of each level. These separate a parity-tap encoder, which stays within a few codes, from one that jumps by half or quarter scale. Extra patterns cover the following:
- overrange set with a partial level underneath, which must still saturate;
- a reset taken while the input is all ones;
- each enable dropped on its own while a bench driver shares the data net, which shows whether the lines are really released and whether the overrange line stays driven.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

    localparam int unsigned DEF_RES = 8;

    // True when threshold k toggles Gray bit j, which happens when k is an
    // odd multiple of 2**j.
    function automatic logic is_tap(input int unsigned k, input int unsigned j);
        int unsigned period;
        period = 32'd2 << j;
        return (k % period) == (32'd1 << j);
    endfunction

endpackage

// File: rtl/fte_gray_enc.sv
module fte_gray_enc
    import flash_enc_pkg::*;
#(
    parameter int unsigned RES = DEF_RES
) (
    input  logic [(1<<RES)-2:0] therm_i,
    output logic [RES-1:0]      gray_o
);
    localparam int unsigned NDATA = (1 << RES) - 1;

    function automatic logic [NDATA-1:0] tap_mask(input int unsigned j);
        logic [NDATA-1:0] m;
        m = '0;
        for (int unsigned k = 1; k <= NDATA; k++) begin
            m[k-1] = is_tap(k, j);
        end
        return m;
    endfunction

    for (genvar j = 0; j < RES; j++) begin : g_bit
        localparam logic [NDATA-1:0] MASK = tap_mask(j);
        assign gray_o[j] = ^(therm_i & MASK);
    end
endmodule

// File: rtl/fte_gray2bin.sv
module fte_gray2bin
    import flash_enc_pkg::*;
#(
    parameter int unsigned RES = DEF_RES
) (
    input  logic [RES-1:0] gray_i,
    output logic [RES-1:0] bin_o
);
    for (genvar i = 0; i < RES; i++) begin : g_bin
        assign bin_o[i] = ^gray_i[RES-1:i];
    end
endmodule

// File: rtl/fte_out_stage.sv
module fte_out_stage
    import flash_enc_pkg::*;
#(
    parameter int unsigned RES = DEF_RES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RES-1:0] bin_i,
    input  logic           ovr_i,
    input  logic           oe_a,
    input  logic           oe_b,
    output logic [RES-1:0] data_o,
    output wire  [RES-1:0] sample_o,
    output logic           ovr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            ovr_o  <= 1'b0;
        end else begin
            data_o <= ovr_i ? {RES{1'b1}} : bin_i;
            ovr_o  <= ovr_i;
        end
    end

    assign sample_o = (oe_a && oe_b) ? data_o : {RES{1'bz}};
endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
    import flash_enc_pkg::*;
#(
    parameter int unsigned RES = DEF_RES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [(1<<RES)-1:0] therm_i,
    input  logic                oe_a,
    input  logic                oe_b,
    output wire  [RES-1:0]      sample_o,
    output logic                ovr_o
);
    localparam int unsigned NCOMP = 1 << RES;
    localparam int unsigned OVR   = NCOMP - 1;

    typedef struct packed {
        logic [RES-1:0] gray;
        logic           ovr;
    } gray_stage_t;

    logic [NCOMP-1:0] therm_q;
    logic [RES-1:0]   gray_d;
    gray_stage_t      st2_q;
    logic [RES-1:0]   bin_d;
    logic [RES-1:0]   data_q;

    // Stage 1: capture the comparator word
    always_ff @(posedge clk) begin
        if (rst) therm_q <= '0;
        else     therm_q <= therm_i;
    end

    fte_gray_enc #(.RES(RES)) u_genc (
        .therm_i (therm_q[OVR-1:0]),
        .gray_o  (gray_d)
    );

    // Stage 2: Gray word plus overrange
    always_ff @(posedge clk) begin
        if (rst) st2_q <= '0;
        else     st2_q <= '{gray: gray_d, ovr: therm_q[OVR]};
    end

    fte_gray2bin #(.RES(RES)) u_g2b (
        .gray_i (st2_q.gray),
        .bin_o  (bin_d)
    );

    // Stage 3: output register and line drivers
    fte_out_stage #(.RES(RES)) u_out (
        .clk      (clk),
        .rst      (rst),
        .bin_i    (bin_d),
        .ovr_i    (st2_q.ovr),
        .oe_a     (oe_a),
        .oe_b     (oe_b),
        .data_o   (data_q),
        .sample_o (sample_o),
        .ovr_o    (ovr_o)
    );
endmodule

// File: rtl/flash_therm_encoder_chk.sv
module flash_therm_encoder_chk
    import flash_enc_pkg::*;
#(
    parameter int unsigned RES = DEF_RES
) (
    input logic                clk,
    input logic                rst,
    input logic [(1<<RES)-1:0] therm_i,
    input logic [RES-1:0]      data_q,
    input logic                ovr_o
);
    localparam int unsigned NCOMP = 1 << RES;

    // Clocks since reset, saturating at 3
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1: first edge after reset sees cleared outputs
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd0) |-> (data_q == '0 && !ovr_o));

    // R3, R4, R5: flag follows the overrange comparator three clocks later
    a_r5_ovr_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (ovr_o == $past(therm_i[NCOMP-1], 3)));

    // R4: overrange saturates the sample
    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        ovr_o |-> (data_q == {RES{1'b1}}));

    // R2: empty thermometer gives zero
    a_r2_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(therm_i, 3) == '0) |-> (data_q == '0));

    // R2: full in-range thermometer gives all ones
    a_r2_full_top: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(therm_i[NCOMP-2:0], 3) == '1) |-> (data_q == {RES{1'b1}}));
endmodule

bind flash_therm_encoder flash_therm_encoder_chk #(.RES(RES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .therm_i (therm_i),
    .data_q  (data_q),
    .ovr_o   (ovr_o)
);

// File: tb/flash_therm_encoder_test.sv
module flash_therm_encoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int RES   = 8;
    localparam int NCOMP = 1 << RES;
    localparam int TOP   = NCOMP - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCOMP-1:0] therm = '0;
    logic             oe_a = 1'b1;
    logic             oe_b = 1'b1;
    logic             tb_drv = 1'b0;
    logic [RES-1:0]   tb_val = '0;
    wire  [RES-1:0]   bus;
    logic             ovr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    assign bus = tb_drv ? tb_val : {RES{1'bz}};

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_therm_encoder #(.RES(RES)) uut (
        .clk      (clk),
        .rst      (rst),
        .therm_i  (therm),
        .oe_a     (oe_a),
        .oe_b     (oe_b),
        .sample_o (bus),
        .ovr_o    (ovr)
    );

    function automatic logic [NCOMP-1:0] level(input int n);
        logic [NCOMP-1:0] v;
        v = '0;
        for (int k = 0; k < n; k++) v[k] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input logic [NCOMP-1:0] w);
        @(negedge clk);
        therm = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset wins over an all-ones input
        therm = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(bus == 0, "R1 sample", int'(bus), 0);
        check(ovr == 1'b0, "R1 ovr", int'(ovr), 0);
        rst = 1'b0;

        // R2 R5 R9: streaming sweep, one level per clock
        for (int i = 0; i <= NCOMP + 3; i++) begin
            @(negedge clk);
            if (i >= 3 && i - 3 <= NCOMP) begin
                int lv;
                int exp_d;
                lv = i - 3;
                exp_d = (lv > TOP) ? TOP : lv;
                check(int'(bus) == exp_d, "R2 R9 stream sample", int'(bus), exp_d);
                check(ovr == (lv == NCOMP), "R5 R4 stream ovr", int'(ovr), int'(lv == NCOMP));
            end
            if (i <= NCOMP) therm = level(i);
        end

        // R3: two edges leave the old result, the third brings the new one
        settle(level(20));
        therm = level(77);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(bus == 20, "R3 after two edges", int'(bus), 20);
        @(negedge clk);
        check(bus == 77, "R3 after three edges", int'(bus), 77);

        // R4: overrange over a partial level
        settle(level(10) | (NCOMP'(1) << TOP));
        check(bus == TOP, "R4 saturate", int'(bus), TOP);
        check(ovr == 1'b1, "R4 flag", int'(ovr), 1);

        // R6: one bubble just below the top of each level
        for (int lv = 2; lv <= TOP; lv++) begin
            logic [NCOMP-1:0] w;
            int d;
            w = level(lv);
            w[lv-2] = 1'b0;
            settle(w);
            d = int'(bus) - lv;
            if (d < 0) d = -d;
            check(d <= 3, "R6 bubble", int'(bus), lv);
            check(ovr == 1'b0, "R5 bubble ovr", int'(ovr), 0);
        end

        // R7 R8: enables
        settle(level(8'h5A));
        tb_val = 8'hA5;
        oe_a = 1'b0;
        tb_drv = 1'b1;
        #1;
        check(bus == 8'hA5, "R7 oe_a low released", int'(bus), 8'hA5);
        check(ovr == 1'b0, "R8 ovr low driven", int'(ovr), 0);
        oe_a = 1'b1;
        oe_b = 1'b0;
        #1;
        check(bus == 8'hA5, "R7 oe_b low released", int'(bus), 8'hA5);
        tb_drv = 1'b0;
        oe_b = 1'b1;
        #1;
        check(bus == 8'h5A, "R7 enabled drives", int'(bus), 8'h5A);
        settle(level(NCOMP));
        oe_a = 1'b0;
        oe_b = 1'b0;
        tb_drv = 1'b1;
        #1;
        check(ovr == 1'b1, "R8 ovr high driven", int'(ovr), 1);
        check(bus == 8'hA5, "R7 both low released", int'(bus), 8'hA5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule